// File: doc/BRIEF.md
# Event-Triggered Micro-Program Sequencer

This block is a small controller that runs a short stored list of register-transfer instructions each time a hardware event pulses. It keeps four general registers. It can read the live values of two counters, and it drives write strobes plus a shared data bus into the match1 and match2 registers of either counter. A typical program samples a counter at the moment of an event, offsets the value by a preset register, and writes the results back as new match thresholds. All of this happens within a few clock cycles of the event.

Software configures the block through two write ports while it is idle. One port loads the program memory and the other sets the register start values. After that, the trigger input alone drives it. Execution starts in the cycle right after the trigger is sampled and retires one instruction per clock. It stops on a stop opcode or after the last memory slot. `busy_o` is high while a program is running.

Instruction word, 8 bits: `[7:5]` opcode, `[4:3]` operand register Ra, `[2:1]` target register Rb, `[0]` counter select (0 = counter 0, 1 = counter 1).

Top module: `uprog_seq`

## Requirements
- R1: When `busy_o` is low and `trig_i` is high at a rising edge, the program starts at address 0. Instruction 0 executes in the following cycle, and `busy_o` is high for that cycle.
- R2: Each instruction takes exactly one clock cycle. Instruction k executes k cycles after instruction 0.
- R3: Opcode 1 (read counter) loads Rb with the value of the selected counter as sampled at the end of its execute cycle.
- R4: Opcode 2 sets Rb to Rb + Ra and opcode 3 sets Rb to Rb - Ra, both modulo 2^16 with no saturation.
- R5: Opcode 4 raises `match1_we_o[sel]` and opcode 5 raises `match2_we_o[sel]` for their execute cycle, with `match_data_o` equal to Ra. At most one strobe is high at any time, and no strobe is high while `busy_o` is low.
- R6: Opcodes 0, 6 and 7 stop the program. A stop instruction spends one cycle with no effect, and `busy_o` is low from the next cycle. Without a stop instruction, the program ends after the instruction at address 7.
- R7: A trigger that arrives while `busy_o` is high, including in the final cycle of a run, is ignored.
- R8: Register values persist from one run to the next. Register writes and program writes made while `busy_o` is high are ignored.
- R9: After reset, `busy_o` and all strobes are low, all registers are zero, and every program slot holds a stop instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_we_i | input | 1 | Program memory write enable |
| prog_addr_i | input | 3 | Program memory write address |
| prog_data_i | input | 8 | Instruction word to write |
| reg_we_i | input | 1 | Register preset write enable |
| reg_addr_i | input | 2 | Register preset address |
| reg_data_i | input | 16 | Register preset value |
| trig_i | input | 1 | Start event pulse |
| cnt0_i | input | 16 | Live value of counter 0 |
| cnt1_i | input | 16 | Live value of counter 1 |
| busy_o | output | 1 | Program running |
| match1_we_o | output | 2 | Match1 write strobe, one bit per counter |
| match2_we_o | output | 2 | Match2 write strobe, one bit per counter |
| match_data_o | output | 16 | Value written with either strobe |

## Verification
The main pattern is an offset program: read a counter, subtract R1, write match1, add R2, write match2. It is swept over counter values and register presets that include zero, small values and values near the 16-bit wrap, so borrow and carry wrap are told apart from saturation. The counter input changes right after the trigger edge, which shows whether the sample is taken in the first execute cycle or before it. A second program has no stop instruction and doubles a value read from counter 1, sweeping several inputs; it separates the end at the last slot from a stop, and counter 1 from counter 0. A repeated-accumulate program, with triggers and configuration writes injected during runs, separates lasting register state from restarts and from writes that slip in while busy.

// File: rtl/uprog_pkg.sv
package uprog_pkg;
  localparam int NREG   = 4;
  localparam int NCNT   = 2;
  localparam int REG_AW = $clog2(NREG);
  localparam int CSEL_W = (NCNT > 1) ? $clog2(NCNT) : 1;

  typedef enum logic [2:0] {
    OP_STOP = 3'd0,
    OP_RDC  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_WM1  = 3'd4,
    OP_WM2  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } op_e;

  typedef struct packed {
    op_e               op;
    logic [REG_AW-1:0] ra;
    logic [REG_AW-1:0] rb;
    logic [CSEL_W-1:0] csel;
  } instr_t;

  localparam int INSTR_W = $bits(instr_t);
endpackage

// File: rtl/uprog_store.sv
module uprog_store
  import uprog_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  instr_t        wdata_i,
  input  logic [AW-1:0] raddr_i,
  output instr_t        instr_o
);
  instr_t mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           mem_q[i] <= '0;
      else if (we_i && waddr_i == AW'(i))    mem_q[i] <= wdata_i;
    end
  end

  assign instr_o = mem_q[raddr_i];
endmodule

// File: rtl/uprog_regs.sv
module uprog_regs #(
  parameter int DATA_W = 16,
  parameter int NREG   = 4,
  localparam int AW    = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [AW-1:0]     cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_data_i,
  input  logic              exe_we_i,
  input  logic [AW-1:0]     exe_addr_i,
  input  logic [DATA_W-1:0] exe_data_i,
  input  logic [AW-1:0]     ra_addr_i,
  input  logic [AW-1:0]     rb_addr_i,
  output logic [DATA_W-1:0] ra_o,
  output logic [DATA_W-1:0] rb_o
);
  logic [NREG-1:0][DATA_W-1:0] regs_q;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                regs_q[i] <= '0;
      else if (exe_we_i && exe_addr_i == AW'(i))  regs_q[i] <= exe_data_i;
      else if (cfg_we_i && cfg_addr_i == AW'(i))  regs_q[i] <= cfg_data_i;
    end
  end

  assign ra_o = regs_q[ra_addr_i];
  assign rb_o = regs_q[rb_addr_i];

  // R8
  regs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exe_we_i && !cfg_we_i) |=> $stable(regs_q));
endmodule

// File: rtl/uprog_exec.sv
module uprog_exec
  import uprog_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                        valid_i,
  input  instr_t                      instr_i,
  input  logic [DATA_W-1:0]           ra_val_i,
  input  logic [DATA_W-1:0]           rb_val_i,
  input  logic [NCNT-1:0][DATA_W-1:0] cnt_i,
  output logic                        wr_en_o,
  output logic [REG_AW-1:0]           wr_addr_o,
  output logic [DATA_W-1:0]           wr_data_o,
  output logic [NCNT-1:0]             m1_we_o,
  output logic [NCNT-1:0]             m2_we_o,
  output logic [DATA_W-1:0]           mdata_o,
  output logic                        stop_o
);
  always_comb begin
    wr_en_o   = 1'b0;
    wr_data_o = rb_val_i;
    stop_o    = 1'b0;
    unique case (instr_i.op)
      OP_RDC: begin wr_en_o = valid_i; wr_data_o = cnt_i[instr_i.csel]; end
      OP_ADD: begin wr_en_o = valid_i; wr_data_o = rb_val_i + ra_val_i; end
      OP_SUB: begin wr_en_o = valid_i; wr_data_o = rb_val_i - ra_val_i; end
      OP_WM1, OP_WM2: ;
      default: stop_o = valid_i;
    endcase
  end

  assign wr_addr_o = instr_i.rb;
  assign mdata_o   = ra_val_i;

  for (genvar c = 0; c < NCNT; c++) begin : g_strb
    assign m1_we_o[c] = valid_i && instr_i.op == OP_WM1 && instr_i.csel == CSEL_W'(c);
    assign m2_we_o[c] = valid_i && instr_i.op == OP_WM2 && instr_i.csel == CSEL_W'(c);
  end
endmodule

// File: rtl/uprog_seq.sv
module uprog_seq
  import uprog_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int PROG_DEPTH = 8,
  localparam int PC_W      = $clog2(PROG_DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               prog_we_i,
  input  logic [PC_W-1:0]    prog_addr_i,
  input  logic [INSTR_W-1:0] prog_data_i,
  input  logic               reg_we_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_data_i,
  input  logic               trig_i,
  input  logic [DATA_W-1:0]  cnt0_i,
  input  logic [DATA_W-1:0]  cnt1_i,
  output logic               busy_o,
  output logic [NCNT-1:0]    match1_we_o,
  output logic [NCNT-1:0]    match2_we_o,
  output logic [DATA_W-1:0]  match_data_o
);
  logic              run_q;
  logic [PC_W-1:0]   pc_q;
  instr_t            instr;
  logic [DATA_W-1:0] ra_val, rb_val, wr_data;
  logic              wr_en, stop, last;
  logic [REG_AW-1:0] wr_addr;

  uprog_store #(.DEPTH(PROG_DEPTH)) u_store (
    .clk_i, .rst_ni,
    .we_i    (prog_we_i && !run_q),
    .waddr_i (prog_addr_i),
    .wdata_i (instr_t'(prog_data_i)),
    .raddr_i (pc_q),
    .instr_o (instr)
  );

  uprog_regs #(.DATA_W(DATA_W), .NREG(NREG)) u_regs (
    .clk_i, .rst_ni,
    .cfg_we_i   (reg_we_i && !run_q),
    .cfg_addr_i (reg_addr_i),
    .cfg_data_i (reg_data_i),
    .exe_we_i   (wr_en),
    .exe_addr_i (wr_addr),
    .exe_data_i (wr_data),
    .ra_addr_i  (instr.ra),
    .rb_addr_i  (instr.rb),
    .ra_o       (ra_val),
    .rb_o       (rb_val)
  );

  uprog_exec #(.DATA_W(DATA_W)) u_exec (
    .valid_i   (run_q),
    .instr_i   (instr),
    .ra_val_i  (ra_val),
    .rb_val_i  (rb_val),
    .cnt_i     ({cnt1_i, cnt0_i}),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .m1_we_o   (match1_we_o),
    .m2_we_o   (match2_we_o),
    .mdata_o   (match_data_o),
    .stop_o    (stop)
  );

  assign last = (pc_q == PC_W'(PROG_DEPTH - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      pc_q  <= '0;
    end else if (!run_q) begin
      run_q <= trig_i;
      pc_q  <= '0;
    end else if (stop || last) begin
      run_q <= 1'b0;
      pc_q  <= '0;
    end else begin
      pc_q  <= pc_q + 1'b1;
    end
  end

  assign busy_o = run_q;

  // R1
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && trig_i) |=> (busy_o && pc_q == '0));
  // R2
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !stop && !last) |=> (busy_o && pc_q == $past(pc_q) + 1'b1));
  // R6
  end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (stop || last)) |=> !busy_o);
  // R5
  strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({match1_we_o, match2_we_o}));
  // R5
  strobe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({match1_we_o, match2_we_o} != '0) |-> busy_o);
endmodule

// File: tb/uprog_seq_tb_top.sv
module uprog_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 16;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        prog_we = 1'b0, reg_we = 1'b0, trig = 1'b0;
  logic [2:0]  prog_addr = '0;
  logic [7:0]  prog_data = '0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_data = '0, cnt0 = '0, cnt1 = '0;
  logic        busy;
  logic [1:0]  m1_we, m2_we;
  logic [15:0] mdata;

  int errors = 0, checks = 0;

  logic [1:0]  cap_m1 [NC], cap_m2 [NC], exp_m1 [NC], exp_m2 [NC];
  logic [15:0] cap_d [NC], exp_d [NC];
  logic        cap_b [NC], exp_b [NC];
  logic [15:0] cnt0_after, cnt1_after;

  always #(CLK_PERIOD/2) clk = ~clk;

  uprog_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .prog_we_i(prog_we), .prog_addr_i(prog_addr),
    .prog_data_i(prog_data), .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_data_i(reg_data),
    .trig_i(trig), .cnt0_i(cnt0), .cnt1_i(cnt1), .busy_o(busy),
    .match1_we_o(m1_we), .match2_we_o(m2_we), .match_data_o(mdata)
  );

  function automatic logic [7:0] ins(int op, int ra, int rb, int cs);
    return {op[2:0], ra[1:0], rb[1:0], cs[0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_prog(input int a, input logic [7:0] d);
    @(negedge clk); prog_we = 1'b1; prog_addr = a[2:0]; prog_data = d;
    @(negedge clk); prog_we = 1'b0;
  endtask

  task automatic wr_reg(input int a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a[1:0]; reg_data = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic clear_exp();
    for (int k = 0; k < NC; k++) begin
      exp_m1[k] = '0; exp_m2[k] = '0; exp_d[k] = '0; exp_b[k] = 1'b0;
    end
  endtask

  // trigger, then record cycle k = execute cycle of instruction k
  task automatic run(input int ncyc, input int retrig_k, input int cfg_k);
    @(negedge clk); trig = 1'b1;
    @(negedge clk);
    for (int k = 0; k < ncyc; k++) begin
      trig = 1'b0; reg_we = 1'b0; prog_we = 1'b0;
      cap_m1[k] = m1_we; cap_m2[k] = m2_we; cap_d[k] = mdata; cap_b[k] = busy;
      if (k == 0) begin cnt0 = cnt0_after; cnt1 = cnt1_after; end
      if (k == retrig_k) trig = 1'b1;
      if (k == cfg_k) begin
        reg_we = 1'b1; reg_addr = 2'd1; reg_data = 16'd999;
        prog_we = 1'b1; prog_addr = 3'd2; prog_data = ins(5, 3, 0, 0);
      end
      @(negedge clk);
    end
    trig = 1'b0; reg_we = 1'b0; prog_we = 1'b0;
  endtask

  task automatic check_run(input string req, input int ncyc);
    bit okb = 1, oks = 1;
    int bk = 0, sk = 0;
    for (int k = 0; k < ncyc; k++) begin
      if (okb && cap_b[k] !== exp_b[k]) begin okb = 0; bk = k; end
      if (oks && (cap_m1[k] !== exp_m1[k] || cap_m2[k] !== exp_m2[k])) begin oks = 0; sk = k; end
      if ((exp_m1[k] | exp_m2[k]) != 0)
        chk(cap_d[k] === exp_d[k], {req, " data"}, 32'(cap_d[k]), 32'(exp_d[k]));
    end
    chk(okb, {req, " busy"}, 32'(bk), 32'(ncyc));
    chk(oks, {req, " strobes"}, {cap_m1[sk], cap_m2[sk]}, {exp_m1[sk], exp_m2[sk]});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] bv [4] = '{16'd0, 16'd5, 16'd100, 16'hFFFF};
    logic [15:0] r1v [3] = '{16'd0, 16'd10, 16'hFFF0};
    logic [15:0] r2v [3] = '{16'd1, 16'd40, 16'hFFFF};
    logic [15:0] acc;

    repeat (3) @(negedge clk);
    // R9: reset state
    chk(busy === 1'b0, "R9 busy", 32'(busy), 0);
    chk({m1_we, m2_we} === 4'b0, "R9 strobes", 32'({m1_we, m2_we}), 0);
    rst_n = 1'b1;
    cnt0_after = 16'h1234; cnt1_after = 16'h4321;

    // R9: empty memory stops at once
    clear_exp(); exp_b[0] = 1'b1;
    run(4, -1, -1);
    check_run("R9 empty", 4);
    // R9: registers start at zero
    wr_prog(0, ins(4, 2, 0, 0));
    clear_exp(); exp_b[0] = 1; exp_b[1] = 1; exp_m1[0] = 2'b01; exp_d[0] = 16'd0;
    run(4, -1, -1);
    check_run("R9 zero regs", 4);

    // R1 R2 R3 R4 R5 R6: offset program swept
    wr_prog(0, ins(1, 0, 3, 0));
    wr_prog(1, ins(3, 1, 3, 0));
    wr_prog(2, ins(4, 3, 0, 1));
    wr_prog(3, ins(2, 2, 3, 0));
    wr_prog(4, ins(5, 3, 0, 1));
    wr_prog(5, ins(0, 0, 0, 0));
    foreach (bv[i]) foreach (r1v[j]) foreach (r2v[m]) begin
      wr_reg(1, r1v[j]); wr_reg(2, r2v[m]);
      cnt0 = bv[i] ^ 16'h5A5A; cnt0_after = bv[i];
      clear_exp();
      for (int k = 0; k < 6; k++) exp_b[k] = 1'b1;
      exp_m1[2] = 2'b10; exp_d[2] = bv[i] - r1v[j];
      exp_m2[4] = 2'b10; exp_d[4] = bv[i] - r1v[j] + r2v[m];
      run(8, -1, -1);
      check_run("R3 R4 R5 offset", 8);
    end

    // R7: trigger mid-run and on the final cycle ignored
    wr_reg(1, 16'd10); wr_reg(2, 16'd40); cnt0_after = 16'd100;
    clear_exp();
    for (int k = 0; k < 6; k++) exp_b[k] = 1'b1;
    exp_m1[2] = 2'b10; exp_d[2] = 16'd90; exp_m2[4] = 2'b10; exp_d[4] = 16'd130;
    run(10, 2, -1);
    check_run("R7 mid trigger", 10);
    run(10, 5, -1);
    check_run("R7 last-cycle trigger", 10);

    // R6 R2 R3: no stop, ends after slot 7, reads counter 1
    wr_prog(0, ins(1, 0, 0, 1));
    wr_prog(1, ins(4, 0, 0, 0));
    wr_prog(2, ins(2, 0, 0, 0));
    wr_prog(3, ins(5, 0, 0, 0));
    wr_prog(4, ins(2, 0, 0, 0));
    wr_prog(5, ins(4, 0, 0, 0));
    wr_prog(6, ins(2, 0, 0, 0));
    wr_prog(7, ins(5, 0, 0, 0));
    for (int v = 0; v < 5; v++) begin
      acc = 16'(v * 16'h3001 + 3);
      cnt1 = ~acc; cnt1_after = acc;
      clear_exp();
      for (int k = 0; k < 8; k++) exp_b[k] = 1'b1;
      exp_m1[1] = 2'b01; exp_d[1] = acc;
      exp_m2[3] = 2'b01; exp_d[3] = acc * 2;
      exp_m1[5] = 2'b01; exp_d[5] = acc * 4;
      exp_m2[7] = 2'b01; exp_d[7] = acc * 8;
      run(10, -1, -1);
      check_run("R6 full depth", 10);
    end

    // R8: persistence, writes while busy ignored; R6 reserved opcode stops
    wr_prog(0, ins(2, 1, 3, 0));
    wr_prog(1, ins(4, 3, 0, 0));
    wr_prog(2, ins(6, 0, 0, 0));
    wr_reg(1, 16'd3); wr_reg(3, 16'd7);
    acc = 16'd7;
    for (int n = 0; n < 4; n++) begin
      acc = acc + 16'd3;
      clear_exp();
      for (int k = 0; k < 3; k++) exp_b[k] = 1'b1;
      exp_m1[1] = 2'b01; exp_d[1] = acc;
      run(6, -1, (n == 2) ? 0 : -1);
      check_run("R8 persist", 6);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule